// File: doc/BRIEF.md
# Four-Queue Weighted Round Egress Scheduler

This block picks which of four egress queues of one output port may send next. Every cycle it reads one "has traffic" flag per queue and offers a one-hot grant together with a valid flag. The downstream side takes that grant by raising `grant_ready` in a cycle where `grant_valid` is high. Queue 3 ranks highest and queue 0 lowest.

Two arbitration methods are available, chosen by `wfq_en`. When `wfq_en` is low, the block uses strict priority: the highest-numbered queue with traffic always wins. When `wfq_en` is high, grants are spread over a round in fixed slot counts. Each queue that has traffic gets 2^i slots. If at least one queue is idle, the highest queue that has traffic gets one extra slot. With all four queues busy this gives 8:4:2:1. With queue 2 idle it gives 9:0:2:1.

Inside a round, each queue keeps a slot counter. At a round boundary the counters are loaded from the flags that are present at that moment. A round ends once no queue with traffic has slots left.

Back-pressure rule: `grant_valid` is high exactly when some queue flag is set. A grant counts only in a cycle with `grant_valid && grant_ready`. While `grant_ready` is low and the inputs do not change, the offered grant does not change either.

Top module: `wfq_sched`

## Requirements
- R1: With `queue_ne` equal to zero, `grant_valid` is 0 and `grant_q` is 0.
- R2: With `wfq_en` low, `grant_q` has exactly one bit set, at the position of the highest set bit of `queue_ne` (bit i stands for queue i).
- R3: With `wfq_en` high and all four flags set, one round hands out 8 grants to queue 3, then 4 to queue 2, then 2 to queue 1, then 1 to queue 0, and then the round starts again.
- R4: When a round starts with some flags clear, queue i receives 2^i slots if its flag is set and 0 slots if it is clear. The highest set queue receives one slot more. Example: `queue_ne`=4'b1011 gives 9,0,2,1.
- R5: Within a round, the grant goes to the highest-numbered queue that has its flag set and still has slots left.
- R6: In a cycle with `grant_ready` low, no slot is used up. The grant seen in the next cycle is the same, provided the inputs are unchanged.
- R7: A queue whose flag is low in any cycle while other queues have traffic loses the slots it still had in the current round.
- R8: While `queue_ne` is zero, the round state is kept. Once traffic returns, the round continues from where it stopped.
- R9: Whenever `grant_valid` is high, `grant_q` is one-hot, and its set bit belongs to a queue whose flag is set.
- R10: A cycle with `wfq_en` low discards the current round. The first weighted grant after that starts a new round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfq_en | input | 1 | 1 selects weighted rounds, 0 selects strict priority |
| queue_ne | input | 4 | Bit i set when queue i holds traffic |
| grant_valid | output | 1 | A grant is offered |
| grant_ready | input | 1 | Downstream takes the offered grant |
| grant_q | output | 4 | One-hot queue grant, bit i for queue i |

## Verification
The hardest case to reach is a queue that loses its leftover slots in the middle of a round, because this only happens when the queue goes idle for a single stalled cycle while lower queues keep their slots. The bench first takes part of a round, then clears the top flag for one cycle with `grant_ready` low. It then restores all flags and checks that the rest of the round skips the top queue until the counters are reloaded. Every one of the 16 flag patterns is also swept through two full rounds, each started fresh by a single strict cycle.

// File: rtl/wfq_pkg.sv
package wfq_pkg;
  parameter int WFQ_NQ = 4;
  // widest slot count is 2^(NQ-1)+1
  localparam int WFQ_CW = $clog2((1 << (WFQ_NQ - 1)) + 2);
endpackage

// File: rtl/wfq_prio_pick.sv
module wfq_prio_pick #(
  parameter int NQ = wfq_pkg::WFQ_NQ
) (
  input  logic [NQ-1:0] req,
  output logic [NQ-1:0] onehot
);
  // ascending scan so the highest requester overwrites lower ones
  always_comb begin
    onehot = '0;
    for (int i = 0; i < NQ; i++) begin
      if (req[i]) onehot = NQ'(1) << i;
    end
  end
endmodule

// File: rtl/wfq_weight_calc.sv
module wfq_weight_calc #(
  parameter int NQ = wfq_pkg::WFQ_NQ,
  localparam int CW = $clog2((1 << (NQ - 1)) + 2)
) (
  input  logic [NQ-1:0]         ne,
  input  logic [NQ-1:0]         top_ne,
  output logic [NQ-1:0][CW-1:0] weight
);
  logic some_idle;
  assign some_idle = ~&ne;

  genvar gi;
  generate
    for (gi = 0; gi < NQ; gi++) begin : g_w
      assign weight[gi] = ne[gi]
        ? CW'((1 << gi) + ((top_ne[gi] && some_idle) ? 1 : 0))
        : '0;
    end
  endgenerate
endmodule

// File: rtl/wfq_credit_bank.sv
module wfq_credit_bank #(
  parameter int NQ = wfq_pkg::WFQ_NQ,
  localparam int CW = $clog2((1 << (NQ - 1)) + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NQ-1:0]         ne,
  input  logic [NQ-1:0][CW-1:0] weight,
  input  logic                  take,
  input  logic [NQ-1:0]         grant,
  output logic [NQ-1:0]         avail
);
  logic [NQ-1:0][CW-1:0] cred_q, cred_d, eff;
  logic [NQ-1:0]         has;
  logic                  round_over;

  always_comb begin
    for (int i = 0; i < NQ; i++) has[i] = |cred_q[i];
  end

  assign round_over = ~|(ne & has);

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      eff[i]   = round_over ? weight[i] : cred_q[i];
      avail[i] = ne[i] && (|eff[i]);
    end
  end

  always_comb begin
    cred_d = cred_q;
    if (!en) begin
      cred_d = '0;
    end else if (|ne) begin
      for (int i = 0; i < NQ; i++) begin
        if (!ne[i])    cred_d[i] = '0;
        else if (take) cred_d[i] = eff[i] - CW'(grant[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cred_q <= '0;
    else        cred_q <= cred_d;
  end

  // R4: no counter ever exceeds the largest slot count
  generate
    for (genvar gi = 0; gi < NQ; gi++) begin : g_cap
      p_credit_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cred_q[gi] <= CW'((1 << (NQ - 1)) + 1));
    end
  endgenerate

  // R8: idle port keeps its round state
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ne == '0) |=> $stable(cred_q));

  // R10: strict cycle clears the round
  p_strict_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cred_q == '0);
endmodule

// File: rtl/wfq_sched.sv
module wfq_sched #(
  parameter int NQ = wfq_pkg::WFQ_NQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wfq_en,
  input  logic [NQ-1:0] queue_ne,
  output logic          grant_valid,
  input  logic          grant_ready,
  output logic [NQ-1:0] grant_q
);
  localparam int CW = $clog2((1 << (NQ - 1)) + 2);

  logic [NQ-1:0]         top_ne, avail, wgt_pick;
  logic [NQ-1:0][CW-1:0] weight;
  logic                  take;

  wfq_prio_pick #(.NQ(NQ)) u_top_pick (.req(queue_ne), .onehot(top_ne));

  wfq_weight_calc #(.NQ(NQ)) u_weight (
    .ne(queue_ne), .top_ne(top_ne), .weight(weight)
  );

  wfq_credit_bank #(.NQ(NQ)) u_bank (
    .clk(clk), .rst_n(rst_n), .en(wfq_en), .ne(queue_ne),
    .weight(weight), .take(take), .grant(grant_q), .avail(avail)
  );

  wfq_prio_pick #(.NQ(NQ)) u_wgt_pick (.req(avail), .onehot(wgt_pick));

  assign grant_valid = |queue_ne;
  assign grant_q     = wfq_en ? wgt_pick : top_ne;
  assign take        = grant_valid && grant_ready && wfq_en;

  // R9: one-hot grant to a queue with traffic
  p_onehot_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(grant_q) == 1 && (grant_q & ~queue_ne) == '0));

  // R1: nothing offered when idle
  p_idle_nogrant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant_q == '0);

  // R2: in strict mode no busy queue ranks above the grant
  p_strict_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wfq_en && grant_valid) |-> (queue_ne & ~((grant_q << 1) - NQ'(1))) == '0);

  // R6: a stalled grant persists while inputs hold
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=>
      (($stable(queue_ne) && $stable(wfq_en)) -> $stable(grant_q)));
endmodule

// File: tb/tb_wfq_sched.sv
module tb_wfq_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfq_en = 1'b0;
  logic [3:0] queue_ne = 4'b0;
  logic       grant_ready = 1'b0;
  logic       grant_valid;
  logic [3:0] grant_q;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  wfq_sched dut (
    .clk(clk), .rst_n(rst_n), .wfq_en(wfq_en), .queue_ne(queue_ne),
    .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_q(grant_q)
  );

  function automatic int top_of(input logic [3:0] p);
    int t = -1;
    for (int i = 0; i < 4; i++) if (p[i]) t = i;
    return t;
  endfunction

  function automatic int wgt(input logic [3:0] p, input int i);
    if (!p[i]) return 0;
    return (1 << i) + ((i == top_of(p) && p != 4'hF) ? 1 : 0);
  endfunction

  task automatic cyc(input logic [3:0] ne, input logic en, input logic rdy,
                     input logic [3:0] expg, input string tag);
    @(negedge clk);
    queue_ne = ne; wfq_en = en; grant_ready = rdy;
    #5;
    checks++;
    if (grant_q !== expg || grant_valid !== (expg != 4'b0)) begin
      errors++;
      $display("FAIL %s: ne=%b en=%b got valid=%b grant=%b expected valid=%b grant=%b",
               tag, ne, en, grant_valid, grant_q, (expg != 4'b0), expg);
    end
  endtask

  task automatic fresh();
    cyc(4'hF, 1'b0, 1'b0, 4'b1000, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    checks++;
    if (grant_valid !== 1'b0 || grant_q !== 4'b0) begin
      errors++;
      $display("FAIL R1 reset: valid=%b grant=%b expected 0 0", grant_valid, grant_q);
    end
    rst_n = 1'b1;

    // R2: strict priority over every pattern, ready both ways
    for (int p = 0; p < 16; p++) begin
      logic [3:0] e;
      e = (p == 0) ? 4'b0 : 4'(1 << top_of(4'(p)));
      cyc(4'(p), 1'b0, 1'b1, e, p == 0 ? "R1" : "R2");
      cyc(4'(p), 1'b0, 1'b0, e, "R2");
    end

    // R3/R4/R5: two full rounds per pattern, from a fresh round
    for (int p = 0; p < 16; p++) begin
      fresh();
      if (p == 0) begin
        cyc(4'b0, 1'b1, 1'b1, 4'b0, "R1");
      end else begin
        for (int r = 0; r < 2; r++)
          for (int i = 3; i >= 0; i--)
            for (int k = 0; k < wgt(4'(p), i); k++)
              cyc(4'(p), 1'b1, 1'b1, 4'(1 << i), p == 15 ? "R3" : "R4_R5");
      end
    end

    // R6 and R8: stall, then idle, then resume the same round
    fresh();
    for (int k = 0; k < 3; k++) cyc(4'hF, 1'b1, 1'b1, 4'b1000, "R3");
    for (int k = 0; k < 3; k++) cyc(4'hF, 1'b1, 1'b0, 4'b1000, "R6");
    for (int k = 0; k < 3; k++) cyc(4'h0, 1'b1, 1'b1, 4'b0000, "R8");
    for (int k = 0; k < 5; k++) cyc(4'hF, 1'b1, 1'b1, 4'b1000, "R8");
    cyc(4'hF, 1'b1, 1'b1, 4'b0100, "R8");

    // R7: top queue idles for one stalled cycle and loses its slots
    fresh();
    for (int k = 0; k < 3; k++) cyc(4'hF, 1'b1, 1'b1, 4'b1000, "R7");
    cyc(4'b0111, 1'b1, 1'b0, 4'b0100, "R7");
    for (int k = 0; k < 4; k++) cyc(4'hF, 1'b1, 1'b1, 4'b0100, "R7");
    for (int k = 0; k < 2; k++) cyc(4'hF, 1'b1, 1'b1, 4'b0010, "R7");
    cyc(4'hF, 1'b1, 1'b1, 4'b0001, "R7");
    cyc(4'hF, 1'b1, 1'b1, 4'b1000, "R7");

    // R10: strict cycle mid-round restarts the round
    fresh();
    for (int k = 0; k < 8; k++) cyc(4'hF, 1'b1, 1'b1, 4'b1000, "R10");
    cyc(4'hF, 1'b1, 1'b1, 4'b0100, "R10");
    fresh();
    cyc(4'hF, 1'b1, 1'b1, 4'b1000, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule